// File: doc/BRIEF.md
# Bus Request and Parking Controller for an External Arbiter

This block sits on the master side of a shared parallel bus when the on-chip arbiter is switched off and an arbiter outside the chip decides who owns the bus. When the local master has a transaction waiting, the block raises a request toward the external arbiter. It then watches the grant input and the bus activity lines, and it starts the address phase only when the bus is safe to drive.

Ownership comes only from the external grant. If the grant lands on the local agent while the bus is idle, the agent becomes the parked owner and keeps its drivers on. This stops the shared lines from floating. When the local agent takes the bus over from some other master, the block first holds its drivers in high impedance for a turnaround of at least `TA_CYCLES` clocks. Only after that does it strobe the address phase. An agent that is already parked skips the turnaround and starts its address phase on the next clock.

The block produces four outputs: the request, a drive enable for the address/data and command lines, a one-clock address-start strobe, and a parked flag. Data phases are handled elsewhere.

Top module: `ext_arb_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_o, drv_en_o, addr_start_o and parked_o are all 0.
- R2: When a transaction is pending and the block is not granted on an idle bus, req_o is 1 from the next clock on, and it stays 1 until the turnaround ends.
- R3: When the local agent is not parked, addr_start_o follows at least TA_CYCLES clocks in which drv_en_o is 0 and the grant was held on an idle bus. It is never raised directly from the idle or requesting condition.
- R4: addr_start_o lasts exactly one clock. During that clock drv_en_o is 1 and req_o is 0.
- R5: When the agent is parked, the grant is held, the bus is idle (frame_i=0 and irdy_i=0) and a transaction is pending, addr_start_o is 1 on the next clock.
- R6: While parked with the grant held and no pending transaction, drv_en_o stays 1.
- R7: When the grant is removed while the agent is parked, drv_en_o and parked_o are 0 on the next clock.
- R8: When the grant is removed during the turnaround, no address phase follows. If a transaction is still pending, req_o stays 1.
- R9: While frame_i or irdy_i is 1, the block does not advance toward the address phase: the address strobe does not rise on the next clock.
- R10: req_o and drv_en_o are never both 1, and exactly one internal state is active at any time.
- R11: A grant received on an idle bus with no transaction pending makes the agent parked. parked_o and drv_en_o become 1 once the turnaround ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xact_pend_i | input | 1 | Local master has a transaction waiting |
| gnt_i | input | 1 | Grant from the external arbiter, 1 = granted |
| frame_i | input | 1 | Bus frame activity, 1 = asserted |
| irdy_i | input | 1 | Bus initiator-ready activity, 1 = asserted |
| req_o | output | 1 | Request to the external arbiter |
| drv_en_o | output | 1 | Output enable for address/data and command drivers |
| addr_start_o | output | 1 | One-clock strobe marking the address phase |
| parked_o | output | 1 | Local agent is the parked bus owner |

## Verification
The assertions assume that the transaction-pending input stays high once it is raised, until the address strobe has been seen. They make no assumption about the grant or the bus activity lines, which may change on any clock. The bench keeps this contract by clearing the pending line only in the cycle after it observes the address strobe. In the random phase it toggles grant, frame and irdy freely, and it raises pending only while nothing is outstanding.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int N_ST = 5;

    typedef enum int unsigned {
        IX_IDLE = 0,
        IX_REQ  = 1,
        IX_TURN = 2,
        IX_ADDR = 3,
        IX_PARK = 4
    } st_ix_e;

    typedef logic [N_ST-1:0] st_vec_t;

    typedef struct packed {
        st_vec_t st;
    } fsm_reg_t;

    localparam st_vec_t ST_RESET = st_vec_t'(1) << IX_IDLE;
endpackage

// File: rtl/ta_timer.sv
module ta_timer #(
    parameter int TA_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_turn,
    output logic done
);
    localparam int CW = (TA_CYCLES < 2) ? 1 : $clog2(TA_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(TA_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!in_turn) begin
            cnt_d = '0;
        end else if (cnt_q < LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q >= LIM);
endmodule

// File: rtl/park_fsm.sv
module park_fsm
    import bp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pend,
    input  logic    gnt,
    input  logic    bus_idle,
    input  logic    ta_done,
    output st_vec_t st_q
);
    fsm_reg_t r_d, r_q;
    logic     gnt_idle;

    assign gnt_idle = gnt && bus_idle;

    always_comb begin
        r_d    = r_q;
        r_d.st = '0;
        if (r_q.st[IX_IDLE]) begin
            if (gnt_idle)  r_d.st[IX_TURN] = 1'b1;
            else if (pend) r_d.st[IX_REQ]  = 1'b1;
            else           r_d.st[IX_IDLE] = 1'b1;
        end else if (r_q.st[IX_REQ]) begin
            if (gnt_idle)  r_d.st[IX_TURN] = 1'b1;
            else if (!pend) r_d.st[IX_IDLE] = 1'b1;
            else           r_d.st[IX_REQ]  = 1'b1;
        end else if (r_q.st[IX_TURN]) begin
            if (!gnt) begin
                if (pend) r_d.st[IX_REQ]  = 1'b1;
                else      r_d.st[IX_IDLE] = 1'b1;
            end else if (ta_done && bus_idle) begin
                if (pend) r_d.st[IX_ADDR] = 1'b1;
                else      r_d.st[IX_PARK] = 1'b1;
            end else begin
                r_d.st[IX_TURN] = 1'b1;
            end
        end else if (r_q.st[IX_ADDR]) begin
            r_d.st[IX_IDLE] = 1'b1;
        end else if (r_q.st[IX_PARK]) begin
            if (!gnt)                 r_d.st[IX_IDLE] = 1'b1;
            else if (pend && bus_idle) r_d.st[IX_ADDR] = 1'b1;
            else                      r_d.st[IX_PARK] = 1'b1;
        end else begin
            r_d.st[IX_IDLE] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RESET};
        end else begin
            r_q <= r_d;
        end
    end

    assign st_q = r_q.st;

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(r_q.st) == 1); // R10
    AST_TURN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st[IX_TURN] && !ta_done) |=> !r_q.st[IX_ADDR]); // R3
    AST_ADDR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.st[IX_TURN] && !r_q.st[IX_PARK]) |=> !r_q.st[IX_ADDR]); // R3
endmodule

// File: rtl/out_decode.sv
module out_decode
    import bp_pkg::*;
(
    input  st_vec_t st,
    input  logic    pend,
    output logic    req,
    output logic    drv_en,
    output logic    addr_start,
    output logic    parked
);
    always_comb begin
        req        = st[IX_REQ] || (st[IX_TURN] && pend);
        drv_en     = st[IX_ADDR] || st[IX_PARK];
        addr_start = st[IX_ADDR];
        parked     = st[IX_PARK];
    end
endmodule

// File: rtl/ext_arb_master.sv
module ext_arb_master
    import bp_pkg::*;
#(
    parameter int TA_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xact_pend_i,
    input  logic gnt_i,
    input  logic frame_i,
    input  logic irdy_i,
    output logic req_o,
    output logic drv_en_o,
    output logic addr_start_o,
    output logic parked_o
);
    logic    bus_idle;
    logic    ta_done;
    st_vec_t st;

    assign bus_idle = !frame_i && !irdy_i;

    ta_timer #(.TA_CYCLES(TA_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_turn (st[IX_TURN]),
        .done    (ta_done)
    );

    park_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (xact_pend_i),
        .gnt      (gnt_i),
        .bus_idle (bus_idle),
        .ta_done  (ta_done),
        .st_q     (st)
    );

    out_decode u_dec (
        .st         (st),
        .pend       (xact_pend_i),
        .req        (req_o),
        .drv_en     (drv_en_o),
        .addr_start (addr_start_o),
        .parked     (parked_o)
    );

    AST_ADDR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_start_o |=> !addr_start_o); // R4
    AST_GNT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (parked_o && !gnt_i) |=> (!drv_en_o && !parked_o)); // R7
    AST_BUSY_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle |=> !addr_start_o); // R9
    AST_PARK_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (parked_o && gnt_i && bus_idle && xact_pend_i) |=> addr_start_o); // R5
endmodule

// File: tb/sim_ext_arb_master.sv
module sim_ext_arb_master;
    localparam int TA = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pend = 1'b0, gnt = 1'b0, frame = 1'b0, irdy = 1'b0;
    logic req_o, drv_en_o, addr_start_o, parked_o;

    int checks = 0;
    int errs = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    ext_arb_master #(.TA_CYCLES(TA)) u0 (
        .clk(clk), .rst_n(rst_n), .xact_pend_i(pend), .gnt_i(gnt),
        .frame_i(frame), .irdy_i(irdy), .req_o(req_o), .drv_en_o(drv_en_o),
        .addr_start_o(addr_start_o), .parked_o(parked_o)
    );

    // behavioural model: 0 idle, 1 requesting, 2 turnaround, 3 address, 4 parked
    int m_st = 0;
    int m_cnt = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st  <= 0;
            m_cnt <= 0;
        end else begin
            automatic bit idle_bus = !frame && !irdy;
            automatic bit done = (m_cnt >= TA - 1);
            automatic int nx = 0;
            case (m_st)
                0: nx = (gnt && idle_bus) ? 2 : (pend ? 1 : 0);
                1: nx = (gnt && idle_bus) ? 2 : (pend ? 1 : 0);
                2: begin
                    if (!gnt) nx = pend ? 1 : 0;
                    else if (done && idle_bus) nx = pend ? 3 : 4;
                    else nx = 2;
                end
                3: nx = 0;
                default: nx = !gnt ? 0 : ((pend && idle_bus) ? 3 : 4);
            endcase
            m_st  <= nx;
            m_cnt <= (m_st == 2) ? ((m_cnt < TA - 1) ? m_cnt + 1 : m_cnt) : 0;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk("R2 model req", req_o, (m_st == 1) || (m_st == 2 && pend));
        chk("R6 model drv_en", drv_en_o, (m_st == 3) || (m_st == 4));
        chk("R4 model addr_start", addr_start_o, m_st == 3);
        chk("R11 model parked", parked_o, m_st == 4);
        chk("R10 req with drive", req_o && drv_en_o, 1'b0);
        if (addr_start_o) pend = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++;
            errs++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req in reset", req_o, 1'b0);
        chk("R1 drv in reset", drv_en_o, 1'b0);
        chk("R1 addr in reset", addr_start_o, 1'b0);
        chk("R1 parked in reset", parked_o, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 req after reset", req_o, 1'b0);
        chk("R1 drv after reset", drv_en_o, 1'b0);

        pend = 1'b1;
        tick(); chk("R2 req raised", req_o, 1'b1); chk("R2 drv off", drv_en_o, 1'b0);
        tick(); chk("R2 req held", req_o, 1'b1);

        frame = 1'b1; gnt = 1'b1;
        tick(); chk("R9 busy no addr", addr_start_o, 1'b0); chk("R9 req held", req_o, 1'b1);
        tick(); chk("R9 busy still no drive", drv_en_o, 1'b0);
        frame = 1'b0;
        tick(); chk("R3 turnaround drv off", drv_en_o, 1'b0); chk("R3 no early addr", addr_start_o, 1'b0);
        chk("R2 req in turnaround", req_o, 1'b1);
        tick(); chk("R4 addr strobe", addr_start_o, 1'b1); chk("R4 drv on", drv_en_o, 1'b1);
        chk("R4 req dropped", req_o, 1'b0);
        tick(); chk("R4 strobe one clock", addr_start_o, 1'b0);
        tick(); chk("R11 turnaround before park", drv_en_o, 1'b0);
        tick(); chk("R11 parked", parked_o, 1'b1); chk("R11 parked drives", drv_en_o, 1'b1);
        for (int i = 0; i < 3; i++) begin
            tick(); chk("R6 parked keeps drive", drv_en_o, 1'b1);
        end

        pend = 1'b1;
        tick(); chk("R5 parked fast start", addr_start_o, 1'b1);
        tick(); tick(); tick(); chk("R11 re-parked", parked_o, 1'b1);

        gnt = 1'b0;
        tick(); chk("R7 drive released", drv_en_o, 1'b0); chk("R7 parked cleared", parked_o, 1'b0);

        pend = 1'b1;
        tick(); chk("R2 request again", req_o, 1'b1);
        gnt = 1'b1;
        tick(); chk("R3 turnaround entered", drv_en_o, 1'b0);
        gnt = 1'b0;
        tick(); chk("R8 no addr after loss", addr_start_o, 1'b0); chk("R8 req kept", req_o, 1'b1);
        tick(); chk("R8 still no addr", addr_start_o, 1'b0);
        gnt = 1'b1;
        tick(); chk("R3 second turnaround", drv_en_o, 1'b0);
        tick(); chk("R3 addr after turnaround", addr_start_o, 1'b1);

        for (int i = 0; i < 3000; i++) begin
            tick();
            if ($urandom_range(7) == 0) gnt = ~gnt;
            frame = ($urandom_range(3) == 0);
            irdy  = ($urandom_range(3) == 0);
            if (!pend && $urandom_range(3) == 0) pend = 1'b1;
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule